// File: doc/BRIEF.md
# Serial Chip-Select Demultiplexer

This block connects one word-level serial master port to three downstream slave ports. Three active-low chip-select lines, one for each downstream channel, are sampled on every clock edge and decide which channel receives the next transfer word. The answer from that channel goes back to the master. If no channel is enabled, the transfer finishes at once with a zero word and no downstream port sees it.

A transfer begins when the master raises `req_valid` while the block is idle. The block fixes its channel choice at that moment. It forwards the word as a single-cycle request on the chosen port and waits for that port's response. It then returns the response as a single-cycle `rsp_valid` pulse. Five named states control the sequence. `ST_IDLE` takes a request and moves to `ST_ISSUE` when some channel is enabled, or to `ST_EMPTY` when none is. `ST_ISSUE` always moves on to `ST_WAIT`. `ST_WAIT` moves to `ST_DONE` when the latched channel answers. `ST_DONE` and `ST_EMPTY` both return to `ST_IDLE`.

Top module: `cs_word_demux`

## Requirements
- R1: During reset, `rsp_valid` and every `dn_req_valid` bit are low, and all channels are disabled. A request accepted on the first edge after reset is released therefore sees no enabled channel and completes with zero.
- R2: Bit i of `cs_n` enables channel i while it is low. It is sampled into an enable register on each clock edge, so a request that arrives in the same cycle as a chip-select change uses the enables sampled on the previous edge.
- R3: When more than one channel is enabled, channel 0 wins over channels 1 and 2, and channel 1 wins over channel 2.
- R4: The cycle after a request is accepted with a channel enabled, exactly one `dn_req_valid` bit (the chosen channel's) is high for one cycle, and `dn_req_data` carries the accepted word. The other ports keep their request valid low for the whole transfer.
- R5: The cycle after the chosen channel raises its `dn_rsp_valid` bit, `rsp_valid` is high for exactly one cycle. `rsp_data` then equals that channel's slot `dn_rsp_data[i*DATA_W +: DATA_W]`.
- R6: When no channel is enabled at acceptance, `rsp_valid` is high in the following cycle with `rsp_data` = 0, and no `dn_req_valid` bit rises.
- R7: The channel is latched at acceptance. Chip-select changes during a transfer do not redirect it, and the response is taken from the latched channel.
- R8: A `dn_rsp_valid` pulse from a channel other than the latched one has no effect. `rsp_valid` stays low and the transfer keeps waiting.
- R9: `req_valid` raised while a transfer is in flight is ignored. After the response, no further downstream request and no further `rsp_valid` follow.
- R10: `rsp_valid` stays low while the block waits for the downstream response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | CH_N | Active-low chip-select, one bit per channel |
| req_valid | input | 1 | Master transfer request |
| req_data | input | DATA_W | Master transfer word |
| rsp_valid | output | 1 | Single-cycle completion pulse to the master |
| rsp_data | output | DATA_W | Returned word (zero when no channel was enabled) |
| dn_req_valid | output | CH_N | Per-channel single-cycle request |
| dn_req_data | output | DATA_W | Word forwarded to the chosen channel |
| dn_rsp_valid | input | CH_N | Per-channel response strobe |
| dn_rsp_data | input | CH_N*DATA_W | Per-channel response words, channel i in slot i |

## Verification
Some rules are checked by the assertions on every cycle: the downstream request valids are never more than one-hot and last one cycle, `rsp_valid` is a single-cycle pulse and stays low during `ST_WAIT`, the zero completion follows when nothing is enabled, and channel 0 and channel 1 take precedence. Other behaviours only the bench scenarios can show. These are the data path from the chosen slot, latching of the channel against chip-select changes in flight, rejection of stray responses and of requests made while busy, and the one-edge sampling delay of the chip-select lines. The reset-release case is also scenario-only: a request accepted on the first edge must see all channels disabled.

// File: rtl/cs_demux_pkg.sv
`timescale 1ns/1ps
package cs_demux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_EMPTY = 3'd4
    } dmx_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cs_demux_sync.sv
`timescale 1ns/1ps
module cs_demux_sync #(
    parameter int CH_N = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] cs_n,
    output logic [CH_N-1:0] en_q
);

    // Chip-selects are active low; channel enables come up disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= ~cs_n;
        end
    end

endmodule

// File: rtl/cs_demux_prio.sv
`timescale 1ns/1ps
module cs_demux_prio #(
    parameter int CH_N  = 3,
    parameter int IDX_W = 2
) (
    input  logic [CH_N-1:0]  en,
    output logic             any_en,
    output logic [IDX_W-1:0] pick_idx
);

    logic [CH_N:0]   seen;
    logic [CH_N-1:0] grant;

    assign seen[0] = 1'b0;

    // Lower index masks every higher index.
    for (genvar i = 0; i < CH_N; i++) begin : g_pick
        assign seen[i+1] = seen[i] | en[i];
        assign grant[i]  = en[i] & ~seen[i];
    end

    assign any_en = seen[CH_N];

    always_comb begin
        pick_idx = '0;
        for (int k = 0; k < CH_N; k++) begin
            if (grant[k]) begin
                pick_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/cs_demux_fsm.sv
`timescale 1ns/1ps
module cs_demux_fsm
    import cs_demux_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  logic              any_en,
    input  logic [IDX_W-1:0]  pick_idx,
    input  logic              sel_rsp_valid,
    input  logic [DATA_W-1:0] sel_rsp_data,
    output dmx_state_e        state,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [DATA_W-1:0] req_word,
    output logic              issue,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    dmx_state_e        nxt;
    logic [DATA_W-1:0] rsp_word;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt = any_en ? ST_ISSUE : ST_EMPTY;
                end
            end
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT: begin
                if (sel_rsp_valid) begin
                    nxt = ST_DONE;
                end
            end
            ST_DONE:  nxt = ST_IDLE;
            ST_EMPTY: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Channel, request word and response word captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_idx  <= '0;
            req_word <= '0;
            rsp_word <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                sel_idx  <= pick_idx;
                req_word <= req_data;
            end
            if (state == ST_WAIT && sel_rsp_valid) begin
                rsp_word <= sel_rsp_data;
            end
        end
    end

    // Outputs
    always_comb begin
        issue     = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: issue = 1'b1;
            ST_WAIT:  ;
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_data  = rsp_word;
            end
            ST_EMPTY: rsp_valid = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cs_demux_route.sv
`timescale 1ns/1ps
module cs_demux_route #(
    parameter int CH_N   = 3,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                   issue,
    input  logic [IDX_W-1:0]       sel_idx,
    input  logic [DATA_W-1:0]      req_word,
    output logic [CH_N-1:0]        dn_req_valid,
    output logic [DATA_W-1:0]      dn_req_data,
    input  logic [CH_N-1:0]        dn_rsp_valid,
    input  logic [CH_N*DATA_W-1:0] dn_rsp_data,
    output logic                   sel_rsp_valid,
    output logic [DATA_W-1:0]      sel_rsp_data
);

    for (genvar i = 0; i < CH_N; i++) begin : g_fan
        assign dn_req_valid[i] = issue && (sel_idx == IDX_W'(i));
    end

    assign dn_req_data = req_word;

    always_comb begin
        sel_rsp_valid = 1'b0;
        sel_rsp_data  = '0;
        for (int k = 0; k < CH_N; k++) begin
            if (sel_idx == IDX_W'(k)) begin
                sel_rsp_valid = dn_rsp_valid[k];
                sel_rsp_data  = dn_rsp_data[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/cs_word_demux.sv
`timescale 1ns/1ps
module cs_word_demux
    import cs_demux_pkg::*;
#(
    parameter int CH_N   = 3,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CH_N-1:0]        cs_n,
    input  logic                   req_valid,
    input  logic [DATA_W-1:0]      req_data,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic [CH_N-1:0]        dn_req_valid,
    output logic [DATA_W-1:0]      dn_req_data,
    input  logic [CH_N-1:0]        dn_rsp_valid,
    input  logic [CH_N*DATA_W-1:0] dn_rsp_data
);

    localparam int IDX_W = idx_width(CH_N);

    logic [CH_N-1:0]   en_q;
    logic              any_en;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  sel_idx;
    logic [DATA_W-1:0] req_word;
    logic              issue;
    logic              sel_rsp_valid;
    logic [DATA_W-1:0] sel_rsp_data;
    dmx_state_e        fsm_state;

    cs_demux_sync #(.CH_N(CH_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .en_q  (en_q)
    );

    cs_demux_prio #(.CH_N(CH_N), .IDX_W(IDX_W)) u_prio (
        .en       (en_q),
        .any_en   (any_en),
        .pick_idx (pick_idx)
    );

    cs_demux_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_data      (req_data),
        .any_en        (any_en),
        .pick_idx      (pick_idx),
        .sel_rsp_valid (sel_rsp_valid),
        .sel_rsp_data  (sel_rsp_data),
        .state         (fsm_state),
        .sel_idx       (sel_idx),
        .req_word      (req_word),
        .issue         (issue),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data)
    );

    cs_demux_route #(.CH_N(CH_N), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_route (
        .issue         (issue),
        .sel_idx       (sel_idx),
        .req_word      (req_word),
        .dn_req_valid  (dn_req_valid),
        .dn_req_data   (dn_req_data),
        .dn_rsp_valid  (dn_rsp_valid),
        .dn_rsp_data   (dn_rsp_data),
        .sel_rsp_valid (sel_rsp_valid),
        .sel_rsp_data  (sel_rsp_data)
    );

endmodule

// File: rtl/cs_demux_checker.sv
`timescale 1ns/1ps
module cs_demux_checker
    import cs_demux_pkg::*;
#(
    parameter int CH_N   = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic [CH_N-1:0]   dn_req_valid,
    input logic [CH_N-1:0]   en_q,
    input dmx_state_e        fsm_state
);

    assert_onehot_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_req_valid));

    assert_dn_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid != '0) |=> (dn_req_valid == '0));

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && req_valid && en_q == '0)
            |=> (rsp_valid && rsp_data == '0 && dn_req_valid == '0));

    assert_ch0_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && req_valid && en_q[0]) |=> dn_req_valid[0]);

    assert_ch1_over_ch2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && req_valid && !en_q[0] && en_q[1])
            |=> dn_req_valid[1]);

    assert_quiet_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_WAIT) |-> !rsp_valid);

endmodule

bind cs_word_demux cs_demux_checker #(.CH_N(CH_N), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .dn_req_valid (dn_req_valid),
    .en_q         (en_q),
    .fsm_state    (fsm_state)
);

// File: tb/test_cs_word_demux.sv
`timescale 1ns/1ps
module test_cs_word_demux;

    localparam int CH_N   = 3;
    localparam int DATA_W = 32;
    localparam int NONE   = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [CH_N-1:0]        cs_n = '1;
    logic                   req_valid = 1'b0;
    logic [DATA_W-1:0]      req_data = '0;
    logic                   rsp_valid;
    logic [DATA_W-1:0]      rsp_data;
    logic [CH_N-1:0]        dn_req_valid;
    logic [DATA_W-1:0]      dn_req_data;
    logic [CH_N-1:0]        dn_rsp_valid = '0;
    logic [CH_N*DATA_W-1:0] dn_rsp_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cs_word_demux #(.CH_N(CH_N), .DATA_W(DATA_W)) i_cs_word_demux (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .req_valid    (req_valid),
        .req_data     (req_data),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .dn_req_valid (dn_req_valid),
        .dn_req_data  (dn_req_data),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_data  (dn_rsp_data)
    );

    // {cs_n[2:0], expected channel (3 = none), word}
    localparam logic [36:0] VEC [0:7] = '{
        {3'b000, 2'd0, 32'hA5A5_0001},
        {3'b110, 2'd0, 32'h1234_5678},
        {3'b101, 2'd1, 32'hDEAD_BEEF},
        {3'b011, 2'd2, 32'h0F0F_F0F0},
        {3'b001, 2'd1, 32'h7777_0002},
        {3'b010, 2'd0, 32'hC001_D00D},
        {3'b100, 2'd0, 32'h0000_00FF},
        {3'b111, 2'd3, 32'hFFFF_FFFF}
    };

    function automatic logic [DATA_W-1:0] slot_val(input int ch, input logic [DATA_W-1:0] d);
        return d ^ (32'h0101_0101 * (ch + 1));
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill_slots(input logic [DATA_W-1:0] d);
        dn_rsp_data = {slot_val(2, d), slot_val(1, d), slot_val(0, d)};
    endtask

    // One transfer; stress adds a chip-select flip, a busy request and stray responses.
    task automatic xfer(input logic [2:0] csn, input logic [DATA_W-1:0] d,
                        input int exp_ch, input int lat, input bit stress);
        cs_n = csn;
        @(negedge clk);
        req_valid = 1'b1;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_ch == NONE) begin
            check(rsp_valid && rsp_data == '0 && dn_req_valid == '0, "R6",
                  {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, 32'd0});
            @(negedge clk);
            check(!rsp_valid && dn_req_valid == '0, "R6", {63'd0, rsp_valid}, 64'd0);
            return;
        end
        check(dn_req_valid == (3'b001 << exp_ch), "R3", {61'd0, dn_req_valid},
              {61'd0, 3'b001 << exp_ch});
        check(dn_req_data == d, "R4", {32'd0, dn_req_data}, {32'd0, d});
        if (stress) begin
            cs_n      = ~csn;
            req_valid = 1'b1;
            req_data  = ~d;
        end
        @(negedge clk);
        check(dn_req_valid == '0 && !rsp_valid, "R4", {60'd0, rsp_valid, dn_req_valid}, 64'd0);
        req_valid = 1'b0;
        fill_slots(d);
        for (int c = 0; c < lat; c++) begin
            if (stress) begin
                dn_rsp_valid = ~(3'b001 << exp_ch);
            end
            @(negedge clk);
            dn_rsp_valid = '0;
            check(!rsp_valid, stress ? "R8" : "R10", {63'd0, rsp_valid}, 64'd0);
        end
        dn_rsp_valid = 3'b001 << exp_ch;
        @(negedge clk);
        dn_rsp_valid = '0;
        check(rsp_valid && rsp_data == slot_val(exp_ch, d), stress ? "R7" : "R5",
              {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, slot_val(exp_ch, d)});
        @(negedge clk);
        check(!rsp_valid && dn_req_valid == '0, stress ? "R9" : "R5",
              {60'd0, rsp_valid, dn_req_valid}, 64'd0);
        if (stress) begin
            @(negedge clk);
            check(!rsp_valid && dn_req_valid == '0, "R9",
                  {60'd0, rsp_valid, dn_req_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: quiet outputs in reset even with all selects low and a request
        cs_n = 3'b000;
        req_valid = 1'b1;
        req_data = 32'h5555_AAAA;
        repeat (3) @(negedge clk);
        check(!rsp_valid && dn_req_valid == '0, "R1", {60'd0, rsp_valid, dn_req_valid}, 64'd0);
        // R1: first edge after release sees all channels disabled
        rst_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_data == '0 && dn_req_valid == '0, "R1",
              {31'd0, rsp_valid, rsp_data}, {31'd0, 1'b1, 32'd0});
        @(negedge clk);
        check(!rsp_valid, "R1", {63'd0, rsp_valid}, 64'd0);

        // Table walk: priority, forwarding, response, empty selection
        for (int v = 0; v < 8; v++) begin
            xfer(VEC[v][36:34], VEC[v][31:0], int'(VEC[v][33:32]), v % 3, 1'b0);
        end

        // R2: select change in the request cycle is not yet seen
        cs_n = 3'b111;
        repeat (2) @(negedge clk);
        cs_n = 3'b011;
        req_valid = 1'b1;
        req_data = 32'h2222_3333;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_data == '0 && dn_req_valid == '0, "R2",
              {29'd0, dn_req_valid, rsp_data}, 64'd0);
        @(negedge clk);
        // R2: one edge later channel 2 is enabled
        xfer(3'b011, 32'h2222_3333, 2, 1, 1'b0);

        // R7, R8, R9: flip selects mid-flight, busy request, stray responses
        xfer(3'b110, 32'hABCD_0123, 0, 2, 1'b1);
        xfer(3'b101, 32'h4444_9999, 1, 3, 1'b1);

        // R10: long wait keeps rsp_valid low
        xfer(3'b011, 32'h0BAD_F00D, 2, 6, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule